// File: doc/BRIEF.md
# 1-Wire Bus Master Controller

This block is a single-line 1-Wire bus master. It controls one open-drain data line through a drive-low enable and never drives the line high. The external pullup restores the high level. The master reads the line back through a short synchronizer. All bus timing comes from microsecond parameters, which are scaled by a clocks-per-microsecond parameter into cycle counts.

A user pulses `start_i` with an opcode while the block is idle. Five operations are available:

- a bus reset with presence detection;
- a single-bit write;
- a single-bit read;
- an eight-slot byte write;
- an eight-slot byte read.

Byte operations issue their slots least significant bit first and assemble read data in the same order. `done_o` marks the end of each operation. The read data and presence flags hold their values until the next operation of the same kind.

Top module: `owm_ctrl`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `dq_pull_o`, `presence_o` and `rdata_o` are all zero.
- R2: A start is accepted only while `busy_o` is low. `busy_o` rises one cycle after an accepted start. A start given while busy has no effect on the running operation or its slot count.
- R3: `done_o` is a single-cycle pulse at the end of every operation, and `busy_o` falls in that same cycle.
- R4: Opcode 0 (reset) holds the line low for T_RSTL_US*CLK_PER_US cycles. About T_PDS_US after release, the master samples the line and sets `presence_o` to 1 if it is low, 0 if it is high. `done_o` follows no earlier than T_RSTH_US after release.
- R5: Opcode 1 (bit write) with `wdata_i[0]`=1 pulls the line low for exactly T_LOW1_US*CLK_PER_US cycles, which is well under 15 us.
- R6: Opcode 1 with `wdata_i[0]`=0 pulls the line low for the full slot, T_SLOT_US*CLK_PER_US cycles.
- R7: Opcode 2 (bit read) pulls the line low for T_RDLOW_US*CLK_PER_US cycles, then samples the synchronized line T_SAMP_US after the falling edge. It returns the bit in `rdata_o[0]`, with `rdata_o[7:1]` set to zero.
- R8: After every write or read slot, the line stays released for at least T_REC_US*CLK_PER_US cycles before the next falling edge or before `done_o`.
- R9: Opcode 3 (byte write) issues eight write slots carrying `wdata_i` bits 0 through 7 in that order.
- R10: Opcode 4 (byte read) issues eight read slots, and the bit read in slot k lands in `rdata_o[k]`.
- R11: Opcodes 5, 6 and 7 are ignored: `busy_o` stays low and the line is not pulled. The line is also never pulled while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe |
| op_i | input | 3 | Opcode: 0 reset, 1 write bit, 2 read bit, 3 write byte, 4 read byte |
| wdata_i | input | 8 | Write data; bit 0 used for bit writes |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| rdata_o | output | 8 | Data from the last read operation |
| presence_o | output | 1 | Presence result of the last reset |
| dq_pull_o | output | 1 | Drive-low enable for the open-drain line |
| dq_i | input | 1 | Line level as seen at the pin |

## Verification
The assertions check on every cycle:

- `done_o` is a single-cycle pulse;
- `busy_o` falls only together with `done_o`;
- starts are accepted or refused according to opcode and busy state;
- the line is quiet when idle;
- a low run never exceeds the reset-low length;
- the released gap before each falling edge is at least the recovery time.

Only the bench scenarios can show the behaviour that depends on data and on the bus slave. This covers:

- exact low widths for write 1, write 0 and read slots;
- LSB-first ordering inside a byte write;
- assembly of a byte read from a responding slave model;
- presence found or not found;
- the spacing of the reset release from `done_o`.

// File: rtl/owm_pkg.sv
package owm_pkg;

  typedef enum logic [2:0] {
    OP_RST   = 3'd0,
    OP_WBIT  = 3'd1,
    OP_RBIT  = 3'd2,
    OP_WBYTE = 3'd3,
    OP_RBYTE = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    LK_RST,
    LK_W0,
    LK_W1,
    LK_RD
  } lkind_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOW,
    PH_HIGH,
    PH_REC
  } phase_e;

  function automatic logic op_valid(input logic [2:0] op);
    return op <= 3'd4;
  endfunction

  function automatic lkind_e kind_of(input op_e op, input logic wbit);
    case (op)
      OP_RST:                kind_of = LK_RST;
      OP_RBIT, OP_RBYTE:     kind_of = LK_RD;
      default:               kind_of = wbit ? LK_W1 : LK_W0;
    endcase
  endfunction

endpackage

// File: rtl/owm_sync.sv
module owm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/owm_line_engine.sv
module owm_line_engine
  import owm_pkg::*;
#(
  parameter int RSTL_CYC  = 1920,
  parameter int PDS_CYC   = 280,
  parameter int RSTH_CYC  = 1920,
  parameter int SLOT_CYC  = 260,
  parameter int LOW1_CYC  = 24,
  parameter int RDLOW_CYC = 8,
  parameter int SAMP_CYC  = 60,
  parameter int REC_CYC   = 12
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   go_i,
  input  lkind_e kind_i,
  input  logic   line_i,
  output logic   pull_o,
  output logic   fin_o,
  output logic   bit_o,
  output logic   pres_o
);

  localparam int MAX_A = (RSTL_CYC > RSTH_CYC) ? RSTL_CYC : RSTH_CYC;
  localparam int MAX_C = (MAX_A > SLOT_CYC) ? MAX_A : SLOT_CYC;
  localparam int CW    = $clog2(MAX_C + 1);
  localparam int SAMP_HI = SAMP_CYC - RDLOW_CYC;

  phase_e         phase_q;
  lkind_e         kind_q;
  logic [CW-1:0]  cnt_q;
  logic           pull_q, fin_q, bit_q, pres_q;
  logic [CW-1:0]  low_last, hi_last;

  always_comb begin
    case (kind_q)
      LK_RST:  begin low_last = CW'(RSTL_CYC - 1);  hi_last = CW'(RSTH_CYC - 1); end
      LK_W0:   begin low_last = CW'(SLOT_CYC - 1);  hi_last = CW'(0); end
      LK_W1:   begin low_last = CW'(LOW1_CYC - 1);  hi_last = CW'(SLOT_CYC - LOW1_CYC - 1); end
      default: begin low_last = CW'(RDLOW_CYC - 1); hi_last = CW'(SLOT_CYC - RDLOW_CYC - 1); end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      kind_q  <= LK_RST;
      cnt_q   <= '0;
      pull_q  <= 1'b0;
      fin_q   <= 1'b0;
      bit_q   <= 1'b0;
      pres_q  <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (go_i) begin
            kind_q  <= kind_i;
            pull_q  <= 1'b1;
            cnt_q   <= '0;
            phase_q <= PH_LOW;
          end
        end
        PH_LOW: begin
          if (cnt_q == low_last) begin
            pull_q  <= 1'b0;
            cnt_q   <= '0;
            phase_q <= (kind_q == LK_W0) ? PH_REC : PH_HIGH;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_HIGH: begin
          if (kind_q == LK_RST && cnt_q == CW'(PDS_CYC)) pres_q <= !line_i;
          if (kind_q == LK_RD && cnt_q == CW'(SAMP_HI))  bit_q  <= line_i;
          if (cnt_q == hi_last) begin
            cnt_q <= '0;
            if (kind_q == LK_RST) begin
              phase_q <= PH_IDLE;
              fin_q   <= 1'b1;
            end else begin
              phase_q <= PH_REC;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          // recovery: line released before the slot may end
          if (cnt_q == CW'(REC_CYC - 1)) begin
            cnt_q   <= '0;
            phase_q <= PH_IDLE;
            fin_q   <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign pull_o = pull_q;
  assign fin_o  = fin_q;
  assign bit_o  = bit_q;
  assign pres_o = pres_q;

endmodule

// File: rtl/owm_seq.sv
module owm_seq
  import owm_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [2:0]      op_i,
  input  logic [BITS-1:0] wdata_i,
  input  logic            fin_i,
  input  logic            bit_i,
  input  logic            pres_i,
  output logic            go_o,
  output lkind_e          kind_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [BITS-1:0] rdata_o,
  output logic            presence_o
);

  localparam int LW = $clog2(BITS);

  op_e             op_q;
  logic            busy_q, done_q, go_q, pres_q;
  lkind_e          kind_q;
  logic [BITS-1:0] sh_q, rdata_q;
  logic [LW-1:0]   left_q;
  logic            is_byte;

  assign is_byte = (op_i == OP_WBYTE) || (op_i == OP_RBYTE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_RST;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      go_q    <= 1'b0;
      pres_q  <= 1'b0;
      kind_q  <= LK_RST;
      sh_q    <= '0;
      rdata_q <= '0;
      left_q  <= '0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i && op_valid(op_i)) begin
          busy_q <= 1'b1;
          op_q   <= op_e'(op_i);
          sh_q   <= wdata_i;
          left_q <= is_byte ? LW'(BITS - 1) : '0;
          kind_q <= kind_of(op_e'(op_i), wdata_i[0]);
          go_q   <= 1'b1;
        end
      end else if (fin_i) begin
        if (left_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          case (op_q)
            OP_RST:   pres_q  <= pres_i;
            OP_RBIT:  rdata_q <= {{(BITS-1){1'b0}}, bit_i};
            OP_RBYTE: rdata_q <= {bit_i, sh_q[BITS-1:1]};
            default:  ;
          endcase
        end else begin
          left_q <= left_q - 1'b1;
          sh_q   <= {bit_i, sh_q[BITS-1:1]};
          kind_q <= kind_of(op_q, sh_q[1]);
          go_q   <= 1'b1;
        end
      end
    end
  end

  assign go_o       = go_q;
  assign kind_o     = kind_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign rdata_o    = rdata_q;
  assign presence_o = pres_q;

endmodule

// File: rtl/owm_ctrl.sv
module owm_ctrl
  import owm_pkg::*;
#(
  parameter int CLK_PER_US  = 50,
  parameter int T_RSTL_US   = 480,
  parameter int T_PDS_US    = 70,
  parameter int T_RSTH_US   = 480,
  parameter int T_SLOT_US   = 65,
  parameter int T_LOW1_US   = 6,
  parameter int T_RDLOW_US  = 2,
  parameter int T_SAMP_US   = 15,
  parameter int T_REC_US    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [2:0] op_i,
  input  logic [7:0] wdata_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rdata_o,
  output logic       presence_o,
  output logic       dq_pull_o,
  input  logic       dq_i
);

  localparam int RSTL_CYC  = T_RSTL_US  * CLK_PER_US;
  localparam int PDS_CYC   = T_PDS_US   * CLK_PER_US;
  localparam int RSTH_CYC  = T_RSTH_US  * CLK_PER_US;
  localparam int SLOT_CYC  = T_SLOT_US  * CLK_PER_US;
  localparam int LOW1_CYC  = T_LOW1_US  * CLK_PER_US;
  localparam int RDLOW_CYC = T_RDLOW_US * CLK_PER_US;
  localparam int SAMP_CYC  = T_SAMP_US  * CLK_PER_US;
  localparam int REC_CYC   = T_REC_US   * CLK_PER_US;

  logic   line_s;
  logic   go, fin, rbit, pres;
  lkind_e kind;

  owm_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (dq_i),
    .q_o    (line_s)
  );

  owm_seq #(.BITS(8)) seq_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .op_i       (op_i),
    .wdata_i    (wdata_i),
    .fin_i      (fin),
    .bit_i      (rbit),
    .pres_i     (pres),
    .go_o       (go),
    .kind_o     (kind),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .rdata_o    (rdata_o),
    .presence_o (presence_o)
  );

  owm_line_engine #(
    .RSTL_CYC  (RSTL_CYC),
    .PDS_CYC   (PDS_CYC),
    .RSTH_CYC  (RSTH_CYC),
    .SLOT_CYC  (SLOT_CYC),
    .LOW1_CYC  (LOW1_CYC),
    .RDLOW_CYC (RDLOW_CYC),
    .SAMP_CYC  (SAMP_CYC),
    .REC_CYC   (REC_CYC)
  ) eng_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go),
    .kind_i (kind),
    .line_i (line_s),
    .pull_o (dq_pull_o),
    .fin_o  (fin),
    .bit_o  (rbit),
    .pres_o (pres)
  );

endmodule

// File: rtl/owm_ctrl_chk.sv
module owm_ctrl_chk #(
  parameter int CLK_PER_US = 50,
  parameter int T_RSTL_US  = 480,
  parameter int T_REC_US   = 3
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic [2:0] op_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       dq_pull_o
);

  localparam int RSTL_CYC = T_RSTL_US * CLK_PER_US;
  localparam int REC_CYC  = T_REC_US * CLK_PER_US;
  localparam int LW = $clog2(RSTL_CYC + 2);
  localparam int HW = $clog2(REC_CYC + 1);

  logic [LW-1:0] lo_run;
  logic [HW-1:0] hi_run;
  logic          pull_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_run <= '0;
      hi_run <= HW'(REC_CYC);
      pull_d <= 1'b0;
    end else begin
      pull_d <= dq_pull_o;
      if (dq_pull_o) begin
        hi_run <= '0;
        if (lo_run != LW'(RSTL_CYC + 1)) lo_run <= lo_run + 1'b1;
      end else begin
        lo_run <= '0;
        if (hi_run != HW'(REC_CYC)) hi_run <= hi_run + 1'b1;
      end
    end
  end

  AST_LOW_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_run <= LW'(RSTL_CYC)); // R4

  AST_REC_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_pull_o && !pull_d) |-> (hi_run >= HW'(REC_CYC))); // R8

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R3

  AST_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R3

  AST_START_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && op_i <= 3'd4) |=> busy_o); // R2

  AST_BAD_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && op_i > 3'd4) |=> !busy_o); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !dq_pull_o); // R11

endmodule

bind owm_ctrl owm_ctrl_chk #(
  .CLK_PER_US (CLK_PER_US),
  .T_RSTL_US  (T_RSTL_US),
  .T_REC_US   (T_REC_US)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .op_i      (op_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .dq_pull_o (dq_pull_o)
);

// File: tb/owm_ctrl_tb_top.sv
module owm_ctrl_tb_top;

  localparam int CPU       = 4;
  localparam int RSTL_CYC  = 480 * CPU;
  localparam int RSTH_CYC  = 480 * CPU;
  localparam int SLOT_CYC  = 65 * CPU;
  localparam int LOW1_CYC  = 6 * CPU;
  localparam int RDLOW_CYC = 2 * CPU;
  localparam int REC_CYC   = 3 * CPU;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] op = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic       busy, done, pres, pull;
  logic [7:0] rdata;
  logic       slave_pull = 1'b0;
  wire        dq_line = ~(pull | slave_pull);

  always #10 clk = ~clk;

  owm_ctrl #(.CLK_PER_US(CPU)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .op_i       (op),
    .wdata_i    (wdata),
    .busy_o     (busy),
    .done_o     (done),
    .rdata_o    (rdata),
    .presence_o (pres),
    .dq_pull_o  (pull),
    .dq_i       (dq_line)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // line monitor
  int mon_cyc = 0, mon_lo = 0, mon_hi = 1000000, mon_rel = 0, n_lows = 0;
  int low_w [64];
  int gap_w [64];
  always @(negedge clk) begin
    mon_cyc++;
    if (pull) begin
      if (mon_lo == 0) gap_w[n_lows % 64] = mon_hi;
      mon_lo++;
      mon_hi = 0;
    end else begin
      if (mon_lo > 0) begin
        low_w[n_lows % 64] = mon_lo;
        n_lows++;
        mon_rel = mon_cyc;
      end
      mon_lo = 0;
      mon_hi++;
    end
  end

  // slave model
  bit       rd_mode = 1'b0;
  bit       pres_en = 1'b0;
  logic [7:0] slave_byte = 8'h00;
  int       rd_cnt = 0;
  int       rd_base = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (pull) begin
        if (rd_mode) begin
          if (!slave_byte[3'(rd_cnt - rd_base)]) slave_pull = 1'b1;
          rd_cnt++;
          repeat (120) @(negedge clk);
          slave_pull = 1'b0;
        end else begin
          int w = 0;
          while (pull) begin @(negedge clk); w++; end
          if (w > 1000 && pres_en) begin
            repeat (80) @(negedge clk);
            slave_pull = 1'b1;
            repeat (400) @(negedge clk);
            slave_pull = 1'b0;
          end
        end
        while (pull) @(negedge clk);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #2;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  int done_rel;
  int done_gap;

  task automatic run_op(input logic [2:0] o, input logic [7:0] wd, input bit inject, output int base);
    int t;
    base = n_lows;
    start = 1'b1; op = o; wdata = wd;
    tick();
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    t = 0;
    while (!done && t < 20000) begin
      tick();
      t++;
      if (inject && t == 100) begin start = 1'b1; op = 3'd0; wdata = ~wd; end
      if (inject && t == 101) start = 1'b0;
    end
    chk(done == 1'b1, "R3 done seen", int'(done), 1);
    chk(busy == 1'b0, "R3 busy low with done", int'(busy), 0);
    done_rel = mon_cyc - mon_rel;
    done_gap = mon_hi;
    tick();
    chk(done == 1'b0, "R3 done single cycle", int'(done), 0);
  endtask

  function automatic int exp_wr_w(input logic b);
    return b ? LOW1_CYC : SLOT_CYC;
  endfunction

  initial begin
    repeat (500000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int base;
    logic [7:0] v;
    v = 8'($urandom(32'h1234));
    repeat (3) tick();
    // R1 reset state
    chk(busy == 0 && done == 0 && pull == 0, "R1 idle outputs", int'({busy, done, pull}), 0);
    chk(pres == 0 && rdata == 8'h00, "R1 result regs", int'({pres, rdata}), 0);
    rst_n = 1'b1;
    repeat (3) tick();

    // R4 reset with presence
    pres_en = 1'b1;
    run_op(3'd0, 8'h00, 1'b0, base);
    chk(low_w[base % 64] == RSTL_CYC, "R4 reset low width", low_w[base % 64], RSTL_CYC);
    chk(pres == 1'b1, "R4 presence found", int'(pres), 1);
    chk(done_rel >= RSTH_CYC && done_rel <= RSTH_CYC + 3, "R4 done after reset-high", done_rel, RSTH_CYC + 1);
    // R4 no slave
    pres_en = 1'b0;
    run_op(3'd0, 8'h00, 1'b0, base);
    chk(pres == 1'b0, "R4 presence absent", int'(pres), 0);

    // R5 / R6 bit writes
    run_op(3'd1, 8'h01, 1'b0, base);
    chk(low_w[base % 64] == LOW1_CYC, "R5 write1 low width", low_w[base % 64], LOW1_CYC);
    chk(LOW1_CYC < 15 * CPU, "R5 release before 15us", LOW1_CYC, 15 * CPU);
    chk(done_gap >= REC_CYC, "R8 recovery before done", done_gap, REC_CYC);
    run_op(3'd1, 8'hFE, 1'b0, base);
    chk(low_w[base % 64] == SLOT_CYC, "R6 write0 low width", low_w[base % 64], SLOT_CYC);
    chk(done_gap >= REC_CYC, "R8 recovery after write0", done_gap, REC_CYC);

    // R7 bit reads
    rd_mode = 1'b1;
    rd_base = rd_cnt; slave_byte = 8'h00;
    run_op(3'd2, 8'hFF, 1'b0, base);
    chk(rdata == 8'h00, "R7 read bit 0", int'(rdata), 0);
    chk(low_w[base % 64] == RDLOW_CYC, "R7 read low width", low_w[base % 64], RDLOW_CYC);
    rd_base = rd_cnt; slave_byte = 8'hFF;
    run_op(3'd2, 8'h00, 1'b0, base);
    chk(rdata == 8'h01, "R7 read bit 1", int'(rdata), 1);
    rd_mode = 1'b0;

    // R11 ignored opcodes
    for (int k = 5; k < 8; k++) begin
      start = 1'b1; op = 3'(k);
      tick();
      start = 1'b0;
      repeat (20) begin
        tick();
        if (busy || pull) break;
      end
      chk(!busy && !pull && !done, "R11 opcode ignored", int'({busy, pull, done}), 0);
    end

    // R9 byte writes: directed then random, R2 start-while-busy
    for (int it = 0; it < 7; it++) begin
      logic [7:0] wb;
      wb = (it == 0) ? 8'hA5 : 8'($urandom);
      run_op(3'd3, wb, it == 1, base);
      chk(n_lows - base == 8, "R2 R9 eight slots", n_lows - base, 8);
      for (int b = 0; b < 8; b++) begin
        chk(low_w[(base + b) % 64] == exp_wr_w(wb[b]), "R9 slot width order",
            low_w[(base + b) % 64], exp_wr_w(wb[b]));
        chk(gap_w[(base + b) % 64] >= REC_CYC, "R8 gap before slot",
            gap_w[(base + b) % 64], REC_CYC);
      end
      chk(done_gap >= REC_CYC, "R8 recovery end of byte", done_gap, REC_CYC);
    end

    // R10 byte reads
    rd_mode = 1'b1;
    for (int it = 0; it < 7; it++) begin
      logic [7:0] sb;
      sb = (it == 0) ? 8'h3C : ((it == 1) ? 8'h80 : 8'($urandom));
      rd_base = rd_cnt; slave_byte = sb;
      run_op(3'd4, 8'h00, 1'b0, base);
      chk(rdata == sb, "R10 byte read LSB first", int'(rdata), int'(sb));
      chk(n_lows - base == 8, "R10 eight read slots", n_lows - base, 8);
    end
    rd_mode = 1'b0;
    chk(pres == 1'b0, "R4 presence held", int'(pres), 0);

    finish_run();
  end

endmodule